// File: doc/BRIEF.md
# Turbo Interleaver Address Generator

This block produces the scrambled read addresses used by the internal interleaver of a turbo code, for block sizes K between 40 and 5114. The data positions are arranged as a matrix of R rows and C columns. Each row is reordered by an intra-row permutation that comes from a modular-exponent base sequence S. The rows themselves are reordered by an inter-row mapping. Matrix slots whose address is K or higher are padding and are skipped. The stream therefore carries exactly K distinct addresses, each in the range 0 to K-1.

The block works in two phases. In the setup phase, software-side logic writes the block size, the row and column counts, the prime p, its primitive root v and one entry per row through a small write port. The block then builds S into an internal table. In the run phase, a start pulse makes the block walk the matrix column by column. It emits one address per accepted cycle on a valid/ready stream and raises a one-cycle completion pulse after the last address. The prime, the root and the per-row values are computed outside the block.

Top module: `ilv_addr_gen`

## Requirements
- R1: A configuration write (`cfgWe`) stores `cfgData` into the field that `cfgField` selects: 0 = block size K, 1 = row count R, 2 = column count C, 3 = prime p, 4 = primitive root v, 5 = row entry for row `cfgRow`. A row entry carries the row's target index in bits [12:8] and its intra-row step r in bits [7:0]. Writes are ignored while `busy` is high.
- R2: A `cfgGo` pulse while not busy builds S(0)=1 and S(j)=(v·S(j-1)) mod p for j=1..p-2. `busy` is high for exactly 9·(p-2) cycles of the build.
- R3: The run visits the slots column by column (column j outer, row i inner). Slot (i,j) has the address target(i)·C + U(i,j), where the index into S is (j·r(i)) mod (p-1). When C = p-1, U(i,j) = S[index] - 1.
- R4: When C = p, U(i,j) = S[index] for j < p-1, and U(i,p-1) = 0.
- R5: When C = p+1, the C = p rule applies and U(i,p) = p is added. If also K = R·C, the last row has U(R-1,0) = p and U(R-1,p) = 1, which swaps its first and last entries.
- R6: A slot whose address is K or higher is pruned and not emitted. Exactly K addresses come out, in visiting order.
- R7: While `addrValid` is high and `addrReady` is low, `addrValid` stays high and `addrData` does not change.
- R8: `done` is a single-cycle pulse. It is visible in the cycle after the K-th transfer. The block can then be started again without rebuilding the table.
- R9: `start` has no effect unless a built table is present and the block is idle. This covers a start before any build, during a build and during a run.
- R10: Any accepted configuration write discards the built table, so a later `start` is ignored until `cfgGo` rebuilds the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgField | input | 3 | Field select for the write |
| cfgRow | input | 5 | Row index for row-entry writes |
| cfgData | input | 13 | Write data |
| cfgGo | input | 1 | Build the base-sequence table |
| start | input | 1 | Begin emitting addresses |
| busy | output | 1 | Build or run in progress |
| addrValid | output | 1 | Address available |
| addrReady | input | 1 | Consumer accepts the address |
| addrData | output | 13 | Interleaved address |
| done | output | 1 | Pulse after the K-th address |

## Verification
The assertions assume a consistent configuration. That means p is prime with 7 ≤ p ≤ 257, v is below p, every r(i) is below p-1, C is p-1, p or p+1, the row targets form a permutation of 0..R-1, and K is at most R·C. Under those assumptions the column counter stays below C and the sent count stays below K. Every configuration in the bench meets these conditions: small primes (7 and 11) with coprime steps, swept across all three column modes, with and without pruning and with the full-block swap. Ready is toggled randomly on most runs, so stalls happen on many slots.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int MAX_ROWS  = 20;
  localparam int ROW_W     = $clog2(MAX_ROWS);
  localparam int MAX_PRIME = 257;
  localparam int PW        = $clog2(MAX_PRIME + 1);
  localparam int SDEPTH    = MAX_PRIME - 1;
  localparam int SIDX_W    = $clog2(SDEPTH);
  localparam int AW        = 13;
  localparam int BIT_W     = $clog2(PW);

  typedef enum logic [2:0] {
    FLD_SIZE   = 3'd0,
    FLD_ROWS   = 3'd1,
    FLD_COLS   = 3'd2,
    FLD_PRIME  = 3'd3,
    FLD_ROOT   = 3'd4,
    FLD_ROWENT = 3'd5
  } fieldT;

  typedef struct packed {
    logic              buildInit;
    logic              mulStep;
    logic              mulLast;
    logic              runInit;
    logic              advance;
    logic [BIT_W-1:0]  bitSel;
    logic [SIDX_W-1:0] termIdx;
    logic [ROW_W-1:0]  rowIdx;
    logic [PW-1:0]     colIdx;
  } strobeT;
endpackage

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEn,
  input  logic              cfgWe,
  input  logic [2:0]        cfgField,
  input  logic [ROW_W-1:0]  cfgRow,
  input  logic [AW-1:0]     cfgData,
  input  strobeT            st,
  output logic [AW-1:0]     kVal,
  output logic [ROW_W-1:0]  rowsVal,
  output logic [PW-1:0]     colsVal,
  output logic [PW-1:0]     primeVal,
  output logic              slotValid,
  output logic [AW-1:0]     slotAddr
);
  logic [AW-1:0]     kReg;
  logic [ROW_W-1:0]  rowsReg;
  logic [PW-1:0]     colsReg, primeReg, rootReg;
  logic [ROW_W-1:0]  rowMap [MAX_ROWS];
  logic [SIDX_W-1:0] rInc   [MAX_ROWS];
  logic [PW-1:0]     sMem   [SDEPTH];
  logic [PW-1:0]     accReg, prevReg, tNext;
  logic [PW-1:0]     pm1;

  assign pm1 = primeReg - PW'(1);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      kReg     <= '0;
      rowsReg  <= '0;
      colsReg  <= '0;
      primeReg <= '0;
      rootReg  <= '0;
      for (int i = 0; i < MAX_ROWS; i++) begin
        rowMap[i] <= '0;
        rInc[i]   <= '0;
      end
    end else if (cfgEn && cfgWe) begin
      case (fieldT'(cfgField))
        FLD_SIZE:  kReg     <= cfgData;
        FLD_ROWS:  rowsReg  <= cfgData[ROW_W-1:0];
        FLD_COLS:  colsReg  <= cfgData[PW-1:0];
        FLD_PRIME: primeReg <= cfgData[PW-1:0];
        FLD_ROOT:  rootReg  <= cfgData[PW-1:0];
        FLD_ROWENT: if (int'(cfgRow) < MAX_ROWS) begin
          rowMap[cfgRow] <= cfgData[SIDX_W+ROW_W-1:SIDX_W];
          rInc[cfgRow]   <= cfgData[SIDX_W-1:0];
        end
        default: ;
      endcase
    end
  end

  assign kVal     = kReg;
  assign rowsVal  = rowsReg;
  assign colsVal  = colsReg;
  assign primeVal = primeReg;

  // serial modular multiply: one bit of v per cycle, MSB first
  always_comb begin
    logic [PW:0] dbl, sum;
    dbl = {accReg, 1'b0};
    if (dbl >= {1'b0, primeReg}) dbl = dbl - {1'b0, primeReg};
    sum = dbl + (rootReg[st.bitSel] ? {1'b0, prevReg} : '0);
    if (sum >= {1'b0, primeReg}) sum = sum - {1'b0, primeReg};
    tNext = sum[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg  <= '0;
      prevReg <= '0;
    end else if (st.buildInit) begin
      accReg  <= '0;
      prevReg <= PW'(1);
    end else if (st.mulLast) begin
      accReg  <= '0;
      prevReg <= tNext;
    end else if (st.mulStep) begin
      accReg  <= tNext;
    end
  end

  always_ff @(posedge clk) begin
    if (st.buildInit)     sMem[0]          <= PW'(1);
    else if (st.mulLast)  sMem[st.termIdx] <= tNext;
  end

  // per-row running index (j*r) mod (p-1)
  logic [MAX_ROWS-1:0][SIDX_W-1:0] idxAll;
  for (genvar g = 0; g < MAX_ROWS; g++) begin : g_row
    logic [SIDX_W-1:0] idxReg;
    logic [PW:0]       wrapSum;
    always_comb begin
      wrapSum = {2'b00, idxReg} + {2'b00, rInc[g]};
      if (wrapSum >= {1'b0, pm1}) wrapSum = wrapSum - {1'b0, pm1};
    end
    always_ff @(posedge clk) begin
      if (!rstN || st.runInit) idxReg <= '0;
      else if (st.advance && int'(st.rowIdx) == g) idxReg <= wrapSum[SIDX_W-1:0];
    end
    assign idxAll[g] = idxReg;
  end

  // intra-row value with column-count variants
  logic [SIDX_W-1:0] curIdx;
  logic [PW-1:0]     sVal, uVal;
  logic              lastRow, fullBlock;
  logic [AW:0]       addrFull;

  assign curIdx    = idxAll[st.rowIdx];
  assign sVal      = sMem[curIdx];
  assign lastRow   = (st.rowIdx == rowsReg - ROW_W'(1));
  assign fullBlock = ({1'b0, kReg} ==
                      ((AW+1)'(rowsReg) * (AW+1)'(colsReg)));

  always_comb begin
    if (colsReg == pm1) begin
      uVal = sVal - PW'(1);
    end else if (colsReg == primeReg) begin
      uVal = (st.colIdx == pm1) ? '0 : sVal;
    end else begin
      if (st.colIdx == primeReg)  uVal = primeReg;
      else if (st.colIdx == pm1)  uVal = '0;
      else                        uVal = sVal;
      if (lastRow && fullBlock) begin
        if (st.colIdx == '0)            uVal = primeReg;
        else if (st.colIdx == primeReg) uVal = PW'(1);
      end
    end
  end

  assign addrFull  = (AW+1)'(rowMap[st.rowIdx]) * (AW+1)'(colsReg) + (AW+1)'(uVal);
  assign slotValid = (addrFull < {1'b0, kReg});
  assign slotAddr  = addrFull[AW-1:0];

  a_r2_term_below_prime: assert property (@(posedge clk) disable iff (!rstN)
    st.mulLast |-> (tNext < primeReg));
  a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rstN)
    st.advance |-> ({1'b0, curIdx} < pm1));
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgGo,
  input  logic             start,
  input  logic             addrReady,
  input  logic             slotValid,
  input  logic [AW-1:0]    kVal,
  input  logic [ROW_W-1:0] rowsVal,
  input  logic [PW-1:0]    colsVal,
  input  logic [PW-1:0]    primeVal,
  output strobeT           st,
  output logic             cfgEn,
  output logic             busy,
  output logic             addrValid,
  output logic             done
);
  typedef enum logic [1:0] {ST_EMPTY, ST_BUILD, ST_READY, ST_RUN} stateT;
  stateT             state;
  logic [BIT_W-1:0]  bitCnt;
  logic [SIDX_W-1:0] termCnt;
  logic [ROW_W-1:0]  rowCnt;
  logic [PW-1:0]     colCnt;
  logic [AW-1:0]     sentCnt;
  logic              doneReg;
  logic              idle, goNow, runGo, step, xfer, lastSend;

  assign idle     = (state == ST_EMPTY) || (state == ST_READY);
  assign goNow    = idle && cfgGo && !cfgWe;
  assign runGo    = (state == ST_READY) && start && !cfgWe && !cfgGo;
  assign xfer     = (state == ST_RUN) && slotValid && addrReady;
  assign step     = (state == ST_RUN) && (!slotValid || addrReady);
  assign lastSend = xfer && (sentCnt == kVal - AW'(1));

  always_comb begin
    st.buildInit = goNow;
    st.mulStep   = (state == ST_BUILD);
    st.mulLast   = (state == ST_BUILD) && (bitCnt == '0);
    st.runInit   = runGo;
    st.advance   = step;
    st.bitSel    = bitCnt;
    st.termIdx   = termCnt;
    st.rowIdx    = rowCnt;
    st.colIdx    = colCnt;
  end

  assign cfgEn     = idle;
  assign busy      = !idle;
  assign addrValid = (state == ST_RUN) && slotValid;
  assign done      = doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_EMPTY;
      bitCnt  <= '0;
      termCnt <= '0;
      rowCnt  <= '0;
      colCnt  <= '0;
      sentCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= lastSend;
      case (state)
        ST_EMPTY, ST_READY: begin
          if (cfgWe) begin
            state <= ST_EMPTY;
          end else if (goNow) begin
            state   <= ST_BUILD;
            bitCnt  <= BIT_W'(PW - 1);
            termCnt <= SIDX_W'(1);
          end else if (runGo) begin
            state   <= ST_RUN;
            rowCnt  <= '0;
            colCnt  <= '0;
            sentCnt <= '0;
          end
        end
        ST_BUILD: begin
          if (bitCnt == '0) begin
            bitCnt <= BIT_W'(PW - 1);
            if ({1'b0, termCnt} == primeVal - PW'(2)) state <= ST_READY;
            else termCnt <= termCnt + SIDX_W'(1);
          end else begin
            bitCnt <= bitCnt - BIT_W'(1);
          end
        end
        ST_RUN: begin
          if (step) begin
            if (rowCnt == rowsVal - ROW_W'(1)) begin
              rowCnt <= '0;
              colCnt <= colCnt + PW'(1);
            end else begin
              rowCnt <= rowCnt + ROW_W'(1);
            end
          end
          if (xfer) sentCnt <= sentCnt + AW'(1);
          if (lastSend) state <= ST_READY;
        end
        default: state <= ST_EMPTY;
      endcase
    end
  end

  a_r7_walk_holds_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady) |=> (addrValid && $stable(rowCnt) && $stable(colCnt)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_build_blocks_run: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUILD) |=> (state != ST_RUN));
  a_r6_sent_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (sentCnt < kVal));
  a_r3_col_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (colCnt < colsVal));
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [2:0]       cfgField,
  input  logic [ROW_W-1:0] cfgRow,
  input  logic [AW-1:0]    cfgData,
  input  logic             cfgGo,
  input  logic             start,
  output logic             busy,
  output logic             addrValid,
  input  logic             addrReady,
  output logic [AW-1:0]    addrData,
  output logic             done
);
  strobeT           st;
  logic             cfgEn, slotValid;
  logic [AW-1:0]    kVal;
  logic [ROW_W-1:0] rowsVal;
  logic [PW-1:0]    colsVal, primeVal;

  ilv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgGo(cfgGo), .start(start),
    .addrReady(addrReady), .slotValid(slotValid), .kVal(kVal),
    .rowsVal(rowsVal), .colsVal(colsVal), .primeVal(primeVal),
    .st(st), .cfgEn(cfgEn), .busy(busy), .addrValid(addrValid), .done(done)
  );

  ilv_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgWe(cfgWe),
    .cfgField(cfgField), .cfgRow(cfgRow), .cfgData(cfgData), .st(st),
    .kVal(kVal), .rowsVal(rowsVal), .colsVal(colsVal), .primeVal(primeVal),
    .slotValid(slotValid), .slotAddr(addrData)
  );

  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady) |=> $stable(addrData));
endmodule

// File: tb/ilv_addr_gen_test.sv
`timescale 1ns/1ps
module ilv_addr_gen_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        cfgWe = 0;
  logic [2:0]  cfgField = 0;
  logic [4:0]  cfgRow = 0;
  logic [12:0] cfgData = 0;
  logic        cfgGo = 0;
  logic        start = 0;
  logic        addrReady = 0;
  logic        busy, addrValid, done;
  logic [12:0] addrData;

  int nChecks = 0;
  int nFail = 0;
  int cK, cR, cC, cP, cV;
  int tMap[20];
  int rv[20];
  int expA[0:1023];
  int nExp;

  always #5 clk = ~clk;

  ilv_addr_gen uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgField(cfgField), .cfgRow(cfgRow),
    .cfgData(cfgData), .cfgGo(cfgGo), .start(start), .busy(busy),
    .addrValid(addrValid), .addrReady(addrReady), .addrData(addrData), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int fld, input int row, input int data);
    @(negedge clk);
    cfgWe = 1; cfgField = 3'(fld); cfgRow = 5'(row); cfgData = 13'(data);
    @(negedge clk);
    cfgWe = 0;
  endtask

  // R1: field codes 0..5, row entry = {target[12:8], step[7:0]}
  task automatic loadCfg();
    cfgWrite(0, 0, cK);
    cfgWrite(1, 0, cR);
    cfgWrite(2, 0, cC);
    cfgWrite(3, 0, cP);
    cfgWrite(4, 0, cV);
    for (int i = 0; i < cR; i++) cfgWrite(5, i, (tMap[i] << 8) | rv[i]);
  endtask

  task automatic computeExp();
    int sv[0:300];
    int idx, u, a;
    sv[0] = 1;
    for (int j = 1; j <= cP - 2; j++) sv[j] = (cV * sv[j-1]) % cP;
    nExp = 0;
    for (int j = 0; j < cC; j++) begin
      for (int i = 0; i < cR; i++) begin
        idx = (j * rv[i]) % (cP - 1);
        if (cC == cP - 1) u = sv[idx] - 1;
        else if (j == cP - 1) u = 0;
        else if (j == cP) u = cP;
        else u = sv[idx];
        if (cC == cP + 1 && cK == cR * cC && i == cR - 1) begin
          if (j == 0) u = cP;
          else if (j == cP) u = 1;
        end
        a = tMap[i] * cC + u;
        if (a < cK) begin
          expA[nExp] = a;
          nExp++;
        end
      end
    end
  endtask

  // R2 build; optional start (R9) and config write (R1) injected while busy
  task automatic buildTable(input bit inject);
    int cnt;
    @(negedge clk); cfgGo = 1;
    @(negedge clk); cfgGo = 0;
    cnt = 0;
    #1;
    while (busy && cnt < 5000) begin
      cnt++;
      start = (inject && cnt == 3);
      cfgWe = (inject && cnt == 5);
      cfgField = 3'd0;
      cfgData = 13'd3;
      @(negedge clk);
      start = 0; cfgWe = 0;
      #1;
    end
    chk(cnt == 9 * (cP - 2), "R2 build cycles", cnt, 9 * (cP - 2));
    if (inject) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); #1;
        chk(!addrValid && !busy, "R9 start during build ignored", addrValid, 0);
      end
    end
  endtask

  task automatic runCheck(input string req, input bit randReady);
    int n, guard, prevData;
    bit prevStall;
    computeExp();
    chk(nExp == cK, {req, " expected list size"}, nExp, cK);
    n = 0; guard = 0; prevStall = 0; prevData = 0;
    @(negedge clk); start = 1;
    while (n < cK && guard < 20000) begin
      @(negedge clk);
      start = 0;
      guard++;
      if (prevStall) chk(addrValid && int'(addrData) == prevData, "R7 hold on stall",
                         addrData, prevData);
      addrReady = randReady ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      chk(!done, "R8 no early done", done, 0);
      prevStall = addrValid && !addrReady;
      prevData = addrData;
      if (addrValid && addrReady) begin
        chk(int'(addrData) == expA[n], req, addrData, expA[n]);
        n++;
      end
    end
    chk(n == cK, "R6 address count", n, cK);
    @(negedge clk); addrReady = 0; #1;
    chk(done == 1, "R8 done after last", done, 1);
    chk(!addrValid, "R6 nothing past K", addrValid, 0);
    @(negedge clk); #1;
    chk(done == 0, "R8 done one cycle", done, 0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    chk(!busy && !addrValid && !done, "R8 reset state", {busy, addrValid, done}, 0);

    // p=7, v=3, R=5, C=p-1=6, K=28 (two slots pruned)
    cP = 7; cV = 3; cR = 5; cC = 6; cK = 28;
    tMap[0] = 4; tMap[1] = 3; tMap[2] = 1; tMap[3] = 0; tMap[4] = 2;
    rv[0] = 1; rv[1] = 5; rv[2] = 1; rv[3] = 5; rv[4] = 5;
    loadCfg();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!addrValid && !busy, "R9 start without table ignored", addrValid, 0);
    buildTable(1);
    runCheck("R3 C=p-1 address", 1);
    runCheck("R8 restart same table", 0);

    // C = p, K = R*C
    cC = 7; cK = 35;
    loadCfg(); buildTable(0);
    runCheck("R4 C=p address", 1);

    // C = p+1, K = R*C -> last-row swap
    cC = 8; cK = 40;
    loadCfg(); buildTable(0);
    runCheck("R5 C=p+1 swap", 1);

    // C = p+1 with pruning, no swap
    cK = 37;
    loadCfg(); buildTable(0);
    runCheck("R6 C=p+1 pruned", 1);

    // p=11, v=2, R=10 over three modes
    cP = 11; cV = 2; cR = 10;
    for (int i = 0; i < 10; i++) tMap[i] = (i * 3) % 10;
    rv[0] = 1; rv[1] = 3; rv[2] = 7; rv[3] = 9; rv[4] = 1;
    rv[5] = 3; rv[6] = 7; rv[7] = 9; rv[8] = 3; rv[9] = 1;
    cC = 10; cK = 97;
    loadCfg(); buildTable(0);
    runCheck("R3 p=11 C=p-1", 1);
    cC = 11; cK = 104;
    loadCfg(); buildTable(0);
    runCheck("R4 p=11 C=p pruned", 1);
    cC = 12; cK = 120;
    loadCfg(); buildTable(0);
    runCheck("R5 p=11 swap", 1);

    // R10: a write after the build discards the table
    cfgWrite(0, 0, 119);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(!addrValid && !busy, "R10 table discarded", addrValid, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule